// File: doc/BRIEF.md
# EEPROM Write Guard and Status Unit

This unit sits between the command decoder of a serial EEPROM and its array programming engine. It holds the live copy of the status byte and decides, in every cycle, whether a write to the array at the presented address would be allowed, and whether a write to the status byte would be allowed. The decoder raises one-cycle strobes for each decoded command. The unit accepts or refuses each write request. The programming timer reports the end of every internal write cycle with a one-cycle done strobe.

The state has two parts. The first is a volatile write-enable latch, which write enable and write disable commands set and clear. The second is a busy flag, which is raised when a write is accepted and dropped when the done strobe arrives. There are also three retained bits: a pin-lock enable and a two-bit protection level. The protection level fences off nothing, the top quarter, the top half, or the whole address space. The pin-lock enable makes an external protect pin able to lock the status byte. An accepted status write does not change the retained bits at once. It parks the new value, which takes effect when its write cycle completes. For this reason a change on the pin after a cycle has started cannot stop that cycle.

Top module: `nvm_guard_top`

## Requirements
- R1: After reset, the status byte equals the retained bits of the SR_PRELOAD parameter (bits 7, 3 and 2), with all other bits zero. The enable latch and the busy flag are clear.
- R2: Status byte layout: bit 7 is the pin-lock enable, bits 6..4 always read 0, bits 3..2 are the protection level, bit 1 is the enable latch and bit 0 is the busy flag.
- R3: `arm_i` sets the enable latch and `disarm_i` clears it in the next cycle. Both act whatever the protection state and the busy flag are. When both strobes are high, clearing wins.
- R4: While the enable latch is clear, both `arr_wr_ok_o` and `sr_wr_ok_o` are 0.
- R5: The protection level selects the fenced addresses. Level 00 fences none. Level 01 fences addresses at or above 3/4 of the space (0x1800–0x1FFF for 13 address bits). Level 10 fences the upper half (0x1000–0x1FFF). Level 11 fences all addresses. `arr_wr_ok_o` is 1 exactly when the latch is set, busy is clear and `arr_addr_i` is not fenced.
- R6: `sr_wr_ok_o` is 1 exactly when the latch is set, busy is clear, and the status byte is not pin-locked. The byte is pin-locked when the lock enable is 1 and `wp_pin_i` is low.
- R7: A status request is accepted when `sr_wr_ok_o` is high. An array request is accepted when `arr_wr_ok_o` is high and no status request is present in the same cycle. Acceptance sets busy and clears the latch in the next cycle. Arming in the same cycle does not keep the latch set. A refused request changes nothing.
- R8: An accepted status write takes only data bits 7, 3 and 2. Bits 6..4 and 1..0 are ignored. The new retained bits appear in the status byte in the cycle after the done strobe, not before.
- R9: A done strobe while busy clears busy in the next cycle. A pending status value still commits if `wp_pin_i` changed during the cycle.
- R10: While busy, both permit outputs are 0 and all write requests are ignored.
- R11: A done strobe while not busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_pin_i | input | 1 | Protect pin level; low locks the status byte when the lock enable is set |
| arm_i | input | 1 | Write-enable command strobe |
| disarm_i | input | 1 | Write-disable command strobe |
| arr_wr_req_i | input | 1 | Array write request strobe |
| arr_addr_i | input | ADDR_W | Target array address |
| sr_wr_req_i | input | 1 | Status write request strobe |
| sr_wr_data_i | input | 8 | New status byte value |
| cyc_done_i | input | 1 | End of internal write cycle |
| status_o | output | 8 | Status byte |
| arr_wr_ok_o | output | 1 | Array write at `arr_addr_i` is allowed |
| sr_wr_ok_o | output | 1 | Status write is allowed |

## Verification
Array permission is swept over the four protection levels at addresses on each side of the half and three-quarter boundaries. This separates an off-by-one threshold and a swapped level encoding from correct fencing. Status writes are tried with every combination of lock enable and pin level, and with the pin toggled in the middle of a cycle. This separates pin gating at request time from a wrong abort at commit. Simultaneous strobes are also driven: arm with disarm, arm with an accepted write, and a status request with an array request. These expose the priority rules. A long stretch of random strobes is then compared every cycle against a behavioural model, so that done pulses while idle and requests while busy are also exercised.

// File: rtl/nvm_guard_pkg.sv
`timescale 1ns/1ps
package nvm_guard_pkg;
    localparam int SR_W     = 8;
    localparam int BIT_BUSY = 0;
    localparam int BIT_WEL  = 1;
    localparam int BIT_LVL0 = 2;
    localparam int BIT_LVL1 = 3;
    localparam int BIT_LOCK = 7;
    // bits a status write may change
    localparam logic [SR_W-1:0] SR_WRITABLE = 8'b1000_1100;

    typedef enum logic [1:0] {
        LVL_NONE    = 2'b00,
        LVL_QUARTER = 2'b01,
        LVL_HALF    = 2'b10,
        LVL_ALL     = 2'b11
    } prot_level_e;

    typedef struct packed {
        logic        wel;
        logic        busy;
        logic        lock_en;
        prot_level_e level;
        logic        pend;
        logic        pend_lock_en;
        prot_level_e pend_level;
    } guard_state_t;
endpackage

// File: rtl/nvm_guard_region.sv
`timescale 1ns/1ps
module nvm_guard_region
    import nvm_guard_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  prot_level_e         level_i,
    input  logic [ADDR_W-1:0]   addr_i,
    output logic                hit_o
);
    localparam logic [ADDR_W-1:0] HALF_BASE = ADDR_W'(1) << (ADDR_W - 1);
    localparam logic [ADDR_W-1:0] QTR_BASE  = HALF_BASE | (HALF_BASE >> 1);

    logic in_half;
    logic in_quarter;

    always_comb begin
        in_half    = (addr_i >= HALF_BASE);
        in_quarter = (addr_i >= QTR_BASE);
        unique case (level_i)
            LVL_NONE:    hit_o = 1'b0;
            LVL_QUARTER: hit_o = in_quarter;
            LVL_HALF:    hit_o = in_half;
            default:     hit_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/nvm_guard_perm.sv
`timescale 1ns/1ps
module nvm_guard_perm (
    input  logic wel_i,
    input  logic busy_i,
    input  logic lock_en_i,
    input  logic pin_i,
    input  logic region_hit_i,
    output logic arr_ok_o,
    output logic sr_ok_o
);
    logic open_window;
    logic pin_locked;

    always_comb begin
        open_window = wel_i & ~busy_i;
        pin_locked  = lock_en_i & ~pin_i;
        arr_ok_o    = open_window & ~region_hit_i;
        sr_ok_o     = open_window & ~pin_locked;
    end
endmodule

// File: rtl/nvm_guard_top.sv
`timescale 1ns/1ps
module nvm_guard_top
    import nvm_guard_pkg::*;
#(
    parameter int              ADDR_W     = 13,
    parameter logic [SR_W-1:0] SR_PRELOAD = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_pin_i,
    input  logic              arm_i,
    input  logic              disarm_i,
    input  logic              arr_wr_req_i,
    input  logic [ADDR_W-1:0] arr_addr_i,
    input  logic              sr_wr_req_i,
    input  logic [SR_W-1:0]   sr_wr_data_i,
    input  logic              cyc_done_i,
    output logic [SR_W-1:0]   status_o,
    output logic              arr_wr_ok_o,
    output logic              sr_wr_ok_o
);
    localparam guard_state_t RESET_STATE = '{
        wel:          1'b0,
        busy:         1'b0,
        lock_en:      SR_PRELOAD[BIT_LOCK],
        level:        prot_level_e'(SR_PRELOAD[BIT_LVL1:BIT_LVL0]),
        pend:         1'b0,
        pend_lock_en: 1'b0,
        pend_level:   LVL_NONE
    };

    guard_state_t st_d, st_q;
    logic         region_hit;
    logic         take_sr;
    logic         take_arr;
    logic [SR_W-1:0] sr_kept;

    nvm_guard_region #(.ADDR_W(ADDR_W)) u_region (
        .level_i (st_q.level),
        .addr_i  (arr_addr_i),
        .hit_o   (region_hit)
    );

    nvm_guard_perm u_perm (
        .wel_i        (st_q.wel),
        .busy_i       (st_q.busy),
        .lock_en_i    (st_q.lock_en),
        .pin_i        (wp_pin_i),
        .region_hit_i (region_hit),
        .arr_ok_o     (arr_wr_ok_o),
        .sr_ok_o      (sr_wr_ok_o)
    );

    always_comb begin
        st_d     = st_q;
        sr_kept  = sr_wr_data_i & SR_WRITABLE;
        take_sr  = sr_wr_req_i & sr_wr_ok_o;
        take_arr = arr_wr_req_i & arr_wr_ok_o & ~sr_wr_req_i;

        if (take_sr) begin
            st_d.busy         = 1'b1;
            st_d.pend         = 1'b1;
            st_d.pend_lock_en = sr_kept[BIT_LOCK];
            st_d.pend_level   = prot_level_e'(sr_kept[BIT_LVL1:BIT_LVL0]);
        end else if (take_arr) begin
            st_d.busy = 1'b1;
        end else if (cyc_done_i && st_q.busy) begin
            st_d.busy = 1'b0;
            st_d.pend = 1'b0;
            if (st_q.pend) begin
                st_d.lock_en = st_q.pend_lock_en;
                st_d.level   = st_q.pend_level;
            end
        end

        // clear beats set; an accepted write also clears
        if (disarm_i || take_sr || take_arr) begin
            st_d.wel = 1'b0;
        end else if (arm_i) begin
            st_d.wel = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RESET_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        status_o                      = '0;
        status_o[BIT_LOCK]            = st_q.lock_en;
        status_o[BIT_LVL1:BIT_LVL0]   = st_q.level;
        status_o[BIT_WEL]             = st_q.wel;
        status_o[BIT_BUSY]            = st_q.busy;
    end
endmodule

// File: rtl/nvm_guard_chk.sv
`timescale 1ns/1ps
module nvm_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wp_pin_i,
    input logic       arm_i,
    input logic       disarm_i,
    input logic       arr_wr_req_i,
    input logic       sr_wr_req_i,
    input logic       cyc_done_i,
    input logic [7:0] status_o,
    input logic       arr_wr_ok_o,
    input logic       sr_wr_ok_o
);
    logic accepted;
    assign accepted = (sr_wr_req_i && sr_wr_ok_o) || (arr_wr_req_i && arr_wr_ok_o && !sr_wr_req_i);

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[6:4] == 3'b000); // R2
    AST_ARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i && !disarm_i && !accepted |=> status_o[1]); // R3
    AST_DISARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        disarm_i |=> !status_o[1]); // R3
    AST_NO_LATCH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[1] |-> !arr_wr_ok_o && !sr_wr_ok_o); // R4
    AST_FULL_FENCE: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[3:2] == 2'b11 |-> !arr_wr_ok_o); // R5
    AST_PIN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[7] && !wp_pin_i |-> !sr_wr_ok_o); // R6
    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        accepted |=> status_o[0] && !status_o[1]); // R7
    AST_IDLE_HOLDS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[0] |=> $stable(status_o[7:2])); // R8
    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done_i && status_o[0] |=> !status_o[0]); // R9
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[0] |-> !arr_wr_ok_o && !sr_wr_ok_o); // R10
    AST_IDLE_DONE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[0] && !accepted |=> !status_o[0]); // R11
endmodule

bind nvm_guard_top nvm_guard_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wp_pin_i     (wp_pin_i),
    .arm_i        (arm_i),
    .disarm_i     (disarm_i),
    .arr_wr_req_i (arr_wr_req_i),
    .sr_wr_req_i  (sr_wr_req_i),
    .cyc_done_i   (cyc_done_i),
    .status_o     (status_o),
    .arr_wr_ok_o  (arr_wr_ok_o),
    .sr_wr_ok_o   (sr_wr_ok_o)
);

// File: tb/sim_nvm_guard_top.sv
`timescale 1ns/1ps
module sim_nvm_guard_top;
    localparam int AW    = 13;
    localparam int SPACE = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wp_pin_i = 1'b1;
    logic          arm_i = 1'b0;
    logic          disarm_i = 1'b0;
    logic          arr_wr_req_i = 1'b0;
    logic [AW-1:0] arr_addr_i = '0;
    logic          sr_wr_req_i = 1'b0;
    logic [7:0]    sr_wr_data_i = '0;
    logic          cyc_done_i = 1'b0;
    logic [7:0]    status_o;
    logic          arr_wr_ok_o;
    logic          sr_wr_ok_o;

    always #2.5 clk = ~clk;

    nvm_guard_top #(.ADDR_W(AW), .SR_PRELOAD(8'h00)) u0 (
        .clk(clk), .rst_n(rst_n), .wp_pin_i(wp_pin_i), .arm_i(arm_i),
        .disarm_i(disarm_i), .arr_wr_req_i(arr_wr_req_i), .arr_addr_i(arr_addr_i),
        .sr_wr_req_i(sr_wr_req_i), .sr_wr_data_i(sr_wr_data_i),
        .cyc_done_i(cyc_done_i), .status_o(status_o),
        .arr_wr_ok_o(arr_wr_ok_o), .sr_wr_ok_o(sr_wr_ok_o)
    );

    // behavioural reference state
    int m_wel = 0, m_busy = 0, m_lock = 0, m_lvl = 0;
    int m_pend = 0, m_plock = 0, m_plvl = 0;
    int n_chk = 0, n_fail = 0;
    string cur_req = "R1";

    function automatic int m_status();
        return (m_lock << 7) | (m_lvl << 2) | (m_wel << 1) | m_busy;
    endfunction

    function automatic int m_fenced(int a);
        case (m_lvl)
            0:       return 0;
            1:       return (a >= (SPACE * 3) / 4) ? 1 : 0;
            2:       return (a >= SPACE / 2) ? 1 : 0;
            default: return 1;
        endcase
    endfunction

    function automatic int m_arr_ok();
        return (m_wel == 1 && m_busy == 0 && m_fenced(int'(arr_addr_i)) == 0) ? 1 : 0;
    endfunction

    function automatic int m_sr_ok();
        return (m_wel == 1 && m_busy == 0 && !(m_lock == 1 && wp_pin_i == 1'b0)) ? 1 : 0;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        check(int'(status_o) == m_status(), cur_req, "status", int'(status_o), m_status());
        check(int'(arr_wr_ok_o) == m_arr_ok(), cur_req, "arr_ok", int'(arr_wr_ok_o), m_arr_ok());
        check(int'(sr_wr_ok_o) == m_sr_ok(), cur_req, "sr_ok", int'(sr_wr_ok_o), m_sr_ok());
    endtask

    task automatic model_step();
        int acc_sr, acc_arr, nwel;
        if (!rst_n) begin
            m_wel = 0; m_busy = 0; m_lock = 0; m_lvl = 0; m_pend = 0;
            return;
        end
        acc_sr  = (sr_wr_req_i && m_sr_ok() == 1) ? 1 : 0;
        acc_arr = (arr_wr_req_i && m_arr_ok() == 1 && !sr_wr_req_i) ? 1 : 0;
        nwel = m_wel;
        if (disarm_i || acc_sr == 1 || acc_arr == 1) nwel = 0;
        else if (arm_i) nwel = 1;
        if (acc_sr == 1) begin
            m_busy = 1; m_pend = 1;
            m_plock = int'(sr_wr_data_i[7]);
            m_plvl  = int'(sr_wr_data_i[3:2]);
        end else if (acc_arr == 1) begin
            m_busy = 1;
        end else if (cyc_done_i && m_busy == 1) begin
            m_busy = 0;
            if (m_pend == 1) begin
                m_lock = m_plock; m_lvl = m_plvl;
            end
            m_pend = 0;
        end
        m_wel = nwel;
    endtask

    task automatic tick();
        @(negedge clk);
        compare();
        model_step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        arm_i = 0; disarm_i = 0; arr_wr_req_i = 0; sr_wr_req_i = 0; cyc_done_i = 0;
    endtask

    // arm, write the status byte, finish the cycle
    task automatic load_status(input logic [7:0] v);
        wp_pin_i = 1; arm_i = 1; tick(); arm_i = 0;
        sr_wr_req_i = 1; sr_wr_data_i = v; tick(); sr_wr_req_i = 0;
        cyc_done_i = 1; tick(); cyc_done_i = 0;
        tick();
    endtask

    initial begin
        #750000;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int lvl_exp;
        int addrs[6];
        addrs = '{0, 12'hFFF, 13'h1000, 13'h17FF, 13'h1800, 13'h1FFF};

        // R1 reset state
        #12;
        check(status_o == 8'h00, "R1", "status in reset", int'(status_o), 0);
        @(negedge clk); rst_n = 1;
        @(posedge clk); #1;
        check(status_o == 8'h00, "R1", "status after reset", int'(status_o), 0);
        tick();

        // R4 latch clear blocks everything
        cur_req = "R4";
        arr_wr_req_i = 1; arr_addr_i = 0; tick(); arr_wr_req_i = 0;
        check(status_o == 8'h00, "R4", "refused array write", int'(status_o), 0);
        check(!arr_wr_ok_o && !sr_wr_ok_o, "R4", "permits", {arr_wr_ok_o, sr_wr_ok_o}, 0);

        // R3 arm / disarm / both
        cur_req = "R3";
        arm_i = 1; tick(); arm_i = 0;
        check(status_o == 8'h02, "R3", "arm", int'(status_o), 2);
        disarm_i = 1; tick(); disarm_i = 0;
        check(status_o == 8'h00, "R3", "disarm", int'(status_o), 0);
        arm_i = 1; disarm_i = 1; tick(); idle_inputs();
        check(status_o == 8'h00, "R3", "arm with disarm", int'(status_o), 0);

        // R7 / R10 / R9 / R11 array write cycle
        cur_req = "R7";
        arm_i = 1; tick(); arm_i = 0;
        arr_wr_req_i = 1; arm_i = 1; arr_addr_i = 13'h0123; tick(); idle_inputs();
        check(status_o == 8'h01, "R7", "array accept", int'(status_o), 1);
        cur_req = "R10";
        arm_i = 1; tick(); arm_i = 0;
        check(status_o == 8'h03, "R3", "arm while busy", int'(status_o), 3);
        check(!arr_wr_ok_o && !sr_wr_ok_o, "R10", "busy permits", {arr_wr_ok_o, sr_wr_ok_o}, 0);
        arr_wr_req_i = 1; sr_wr_req_i = 1; tick(); idle_inputs();
        check(status_o == 8'h03, "R10", "requests while busy", int'(status_o), 3);
        cur_req = "R9";
        cyc_done_i = 1; tick(); cyc_done_i = 0;
        check(status_o == 8'h02, "R9", "done clears busy", int'(status_o), 2);
        cur_req = "R11";
        cyc_done_i = 1; tick(); cyc_done_i = 0;
        check(status_o == 8'h02, "R11", "idle done", int'(status_o), 2);

        // R8 / R2 status write ignores unwritable bits, commits at done
        cur_req = "R8";
        sr_wr_req_i = 1; sr_wr_data_i = 8'hFF; tick(); sr_wr_req_i = 0;
        check(status_o == 8'h01, "R8", "bits held during cycle", int'(status_o), 1);
        cyc_done_i = 1; tick(); cyc_done_i = 0;
        check(status_o == 8'h8C, "R2", "committed layout", int'(status_o), 8'h8C);
        check(status_o[6:4] == 3'b000, "R2", "unused bits", int'(status_o[6:4]), 0);

        // R5 level 11 fences all
        cur_req = "R5";
        arm_i = 1; tick(); arm_i = 0;
        arr_addr_i = 0; #1;
        check(arr_wr_ok_o == 1'b0, "R5", "level 11 addr 0", int'(arr_wr_ok_o), 0);

        // R6 pin lock
        cur_req = "R6";
        wp_pin_i = 0; #1;
        check(sr_wr_ok_o == 1'b0, "R6", "locked", int'(sr_wr_ok_o), 0);
        sr_wr_req_i = 1; sr_wr_data_i = 8'h00; tick(); sr_wr_req_i = 0;
        check(status_o == 8'h8E, "R6", "locked request refused", int'(status_o), 8'h8E);
        wp_pin_i = 1; #1;
        check(sr_wr_ok_o == 1'b1, "R6", "pin high unlocks", int'(sr_wr_ok_o), 1);

        // R9 pin drops mid-cycle, commit still happens
        cur_req = "R9";
        sr_wr_req_i = 1; sr_wr_data_i = 8'h04; tick(); sr_wr_req_i = 0;
        wp_pin_i = 0; tick();
        cyc_done_i = 1; tick(); cyc_done_i = 0;
        check(status_o == 8'h04, "R9", "commit despite pin", int'(status_o), 4);
        wp_pin_i = 1;

        // R5 sweep over levels and boundary addresses
        cur_req = "R5";
        for (int lvl = 0; lvl < 4; lvl++) begin
            load_status(8'(lvl << 2));
            arm_i = 1; tick(); arm_i = 0;
            for (int k = 0; k < 6; k++) begin
                arr_addr_i = AW'(addrs[k]); #1;
                case (lvl)
                    0: lvl_exp = 1;
                    1: lvl_exp = (addrs[k] >= 13'h1800) ? 0 : 1;
                    2: lvl_exp = (addrs[k] >= 13'h1000) ? 0 : 1;
                    default: lvl_exp = 0;
                endcase
                check(int'(arr_wr_ok_o) == lvl_exp, "R5", "fence", int'(arr_wr_ok_o), lvl_exp);
                tick();
            end
            disarm_i = 1; tick(); disarm_i = 0;
        end

        // R7 both requests: status wins
        cur_req = "R7";
        load_status(8'h00);
        arm_i = 1; tick(); arm_i = 0;
        arr_wr_req_i = 1; arr_addr_i = 0; sr_wr_req_i = 1; sr_wr_data_i = 8'h08; tick(); idle_inputs();
        cyc_done_i = 1; tick(); cyc_done_i = 0;
        check(status_o == 8'h08, "R7", "status beats array", int'(status_o), 8);

        // random strobes against the model
        cur_req = "R10";
        for (int i = 0; i < 4000; i++) begin
            arm_i        = ($urandom % 4) == 0;
            disarm_i     = ($urandom % 16) == 0;
            arr_wr_req_i = ($urandom % 3) == 0;
            sr_wr_req_i  = ($urandom % 6) == 0;
            cyc_done_i   = ($urandom % 4) == 0;
            if (($urandom % 8) == 0) wp_pin_i = ~wp_pin_i;
            arr_addr_i   = AW'($urandom);
            sr_wr_data_i = 8'($urandom);
            tick();
        end
        idle_inputs();
        tick();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule